// File: doc/BRIEF.md
# Video Pixel Input Formatter

This block sits at the front of a standard-definition video path. It receives one 16-bit parallel pixel bus, clocked at the pixel clock, and optional external horizontal and vertical sync. It turns that bus into a uniform stream of 10-bit component samples. Each of the three component lanes has its own valid strobe. In YCbCr formats the lanes carry Y, Cb and Cr. In RGB input they carry G, B and R.

Two configuration fields and one enable bit choose the formats: a 3-bit input-mode field, a 2-bit bus-width field and an RGB-select bit. The formats are:

- 8-bit interleaved 4:2:2.
- 10-bit interleaved 4:2:2.
- 16-bit split luma/chroma, sampled every second clock.
- 16-bit RGB packed 5-6-5, sampled every second clock.

In the interleaved formats the block finds embedded timing codes, strips them from the sample stream and reports their field, vertical-blank and horizontal-blank flags. In the 16-bit formats only external sync may carry timing, so a code pattern there is passed through as picture data and flagged as blocked.

Top module: `vid_in_fmt`

## Requirements
- R1: The mode field selects standard definition with code 000, which is the only mode this block supports. Codes 001, 010 and 111 are high-definition modes, and 011 to 110 are reserved. For all of these the block sets `mode_unsup`, asserts no valid strobe and reports no timing code. After synchronous reset, every valid, flag and data output is zero.
- R2: With `rgb_sel` low, the width field gives the format: 00 is 8-bit interleaved, 10 is 10-bit interleaved and 01 is 16-bit split. Code 11 is unsupported and is treated as in R1. With `rgb_sel` high, RGB input is used whatever the width field holds.
- R3: In 8-bit mode the sample is `pix_bus[15:8]`, placed in the upper 8 bits of the 10-bit output with two zero bits below. `pix_bus[7:0]` has no effect.
- R4: In 10-bit mode the sample is `pix_bus[15:6]`, and `pix_bus[5:0]` has no effect.
- R5: In interleaved modes, each emitted word drives exactly one strobe, in the repeating order Cb, Y, Cr, Y.
- R6: The interleaved order restarts at Cb for the word that arrives in a cycle where `hsync` rises (high now, low in the previous cycle). It also restarts for the first emitted word after a start-of-active-video code, which is a timing code with H = 0. A code with H = 1 leaves the order unchanged.
- R7: In interleaved modes a timing code is four consecutive words whose upper 8 bits are FF, 00, 00 and then an XY word with bit 7 set. On the XY word `tc_valid` pulses for one cycle, and `tc_field`, `tc_vblank` and `tc_hblank` take XY bits 6, 5 and 4. None of the four words is emitted. A word whose upper 8 bits are all ones is never emitted.
- R8: In 16-bit split mode, `y_data` is `pix_bus[15:8]` and the chroma sample is `pix_bus[7:0]`, both left-justified. Samples are taken on alternate clocks, starting in the cycle where `hsync` rises. Chroma alternates Cb, Cr, starting with Cb at that rise.
- R9: In RGB mode, on the same alternate clocks as R8, all three strobes assert together and `rgb_active` is high. The lanes carry left-justified components: `y_data` = G from `pix_bus[10:5]`, `cb_data` = B from `pix_bus[15:11]` and `cr_data` = R from `pix_bus[4:0]`.
- R10: In the 16-bit modes, a timing-code pattern in `pix_bus[15:8]` across sampled clocks sets `tc_blocked` on the XY sample. `tc_valid` stays low, and the words are still emitted as samples.
- R11: All outputs are registered. A sample appears one clock after the edge that captured it, and `hsync_out` and `vsync_out` are the sync inputs delayed by that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Input-mode field |
| sd_width | input | 2 | Standard-definition bus-width field |
| rgb_sel | input | 1 | Selects 5-6-5 RGB input |
| pix_bus | input | 16 | Parallel pixel bus |
| hsync | input | 1 | External horizontal sync, rising edge active |
| vsync | input | 1 | External vertical sync |
| y_valid | output | 1 | Strobe for the Y (or G) lane |
| y_data | output | 10 | Y or G sample |
| cb_valid | output | 1 | Strobe for the Cb (or B) lane |
| cb_data | output | 10 | Cb or B sample |
| cr_valid | output | 1 | Strobe for the Cr (or R) lane |
| cr_data | output | 10 | Cr or R sample |
| rgb_active | output | 1 | Lanes carry RGB |
| tc_valid | output | 1 | Embedded timing code accepted |
| tc_field | output | 1 | Field bit of the last accepted code |
| tc_vblank | output | 1 | Vertical-blank bit of the last accepted code |
| tc_hblank | output | 1 | Horizontal-blank bit of the last accepted code |
| tc_blocked | output | 1 | Code pattern seen where codes are not allowed |
| mode_unsup | output | 1 | Configuration not supported |
| hsync_out | output | 1 | Delayed hsync |
| vsync_out | output | 1 | Delayed vsync |

## Verification
A wrong interleave phase shows up within the next emitted word as a strobe on the wrong lane. A wrong half-rate toggle shows up within two clocks as strobes on adjacent cycles or on the wrong edge after an `hsync` rise. A corrupted code-history register either leaks a preamble word as a sample or misses the `tc_valid` pulse on the XY word, which is visible in the very cycle the code completes.

// File: rtl/vif_pkg.sv
package vif_pkg;

    localparam int BUS_W  = 16;
    localparam int SMP_W  = 10;
    localparam int KEY_W  = 8;
    localparam int HIST_D = 3;
    localparam int PH_W   = 2;

    localparam logic [2:0] MODE_SD  = 3'b000;
    localparam logic [1:0] WID_8    = 2'b00;
    localparam logic [1:0] WID_10   = 2'b10;
    localparam logic [1:0] WID_16   = 2'b01;

    // bus slice positions
    localparam int KEY_LSB  = BUS_W - KEY_W;
    localparam int W10_LSB  = BUS_W - SMP_W;
    localparam int R_W      = 5;
    localparam int G_W      = 6;
    localparam int B_W      = 5;
    localparam int R_LSB    = 0;
    localparam int G_LSB    = R_LSB + R_W;
    localparam int B_LSB    = G_LSB + G_W;

    typedef enum logic [2:0] {
        FMT_OFF   = 3'd0,
        FMT_IL8   = 3'd1,
        FMT_IL10  = 3'd2,
        FMT_SPLIT = 3'd3,
        FMT_RGB   = 3'd4
    } fmt_e;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] dat;
    } smp_t;

    function automatic fmt_e fmt_decode(input logic [2:0] mode,
                                        input logic [1:0] wid,
                                        input logic       rgb);
        fmt_e f;
        f = FMT_OFF;
        if (mode == MODE_SD) begin
            if (rgb)                 f = FMT_RGB;
            else if (wid == WID_8)   f = FMT_IL8;
            else if (wid == WID_10)  f = FMT_IL10;
            else if (wid == WID_16)  f = FMT_SPLIT;
            else                     f = FMT_OFF;
        end
        return f;
    endfunction

    function automatic logic fmt_is_il(input fmt_e f);
        return (f == FMT_IL8) || (f == FMT_IL10);
    endfunction

    function automatic logic fmt_is_wide(input fmt_e f);
        return (f == FMT_SPLIT) || (f == FMT_RGB);
    endfunction

    function automatic logic [SMP_W-1:0] ljust(input logic [SMP_W-1:0] v,
                                               input int unsigned     bits);
        return v << (SMP_W - bits);
    endfunction

endpackage

// File: rtl/vif_mode_dec.sv
module vif_mode_dec
    import vif_pkg::*;
(
    input  logic [2:0] mode_sel,
    input  logic [1:0] sd_width,
    input  logic       rgb_sel,
    output fmt_e       fmt,
    output logic       unsup
);
    always_comb begin
        fmt   = fmt_decode(mode_sel, sd_width, rgb_sel);
        unsup = (fmt == FMT_OFF);
    end
endmodule

// File: rtl/vif_code_det.sv
module vif_code_det
    import vif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [KEY_W-1:0] key,
    output logic             code_word,
    output logic             xy_hit,
    output logic [2:0]       fvh
);
    logic [HIST_D-1:0][KEY_W-1:0] hist_q;
    logic [HIST_D-1:0]            h_ones;
    logic [HIST_D-1:0]            h_zero;
    logic                         k_ones;
    logic                         k_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q[0] <= key;
            for (int i = 1; i < HIST_D; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    for (genvar gi = 0; gi < HIST_D; gi++) begin : g_flags
        assign h_ones[gi] = &hist_q[gi];
        assign h_zero[gi] = ~|hist_q[gi];
    end

    always_comb begin
        k_ones    = &key;
        k_zero    = ~|key;
        xy_hit    = key[KEY_W-1] & h_zero[0] & h_zero[1] & h_ones[2];
        code_word = k_ones
                  | (k_zero & h_ones[0])
                  | (k_zero & h_zero[0] & h_ones[1])
                  | xy_hit;
        fvh       = key[KEY_W-2 -: 3];
    end
endmodule

// File: rtl/vif_seq.sv
module vif_seq
    import vif_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wide,
    input  logic            hs_rise,
    input  logic            emit,
    input  logic            sav,
    output logic [PH_W-1:0] ph,
    output logic            take,
    output logic            csel
);
    logic [PH_W-1:0] ph_q;
    logic            tgl_q;
    logic            c_q;

    always_comb begin
        ph   = hs_rise ? '0 : ph_q;
        take = wide & (hs_rise | ~tgl_q);
        csel = hs_rise ? 1'b0 : c_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            tgl_q <= 1'b0;
            c_q   <= 1'b0;
        end else begin
            if (sav)       ph_q <= '0;
            else if (emit) ph_q <= ph + 1'b1;
            else           ph_q <= ph;
            tgl_q <= take;
            c_q   <= take ? ~csel : csel;
        end
    end
endmodule

// File: rtl/vid_in_fmt.sv
module vid_in_fmt
    import vif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [1:0]       sd_width,
    input  logic             rgb_sel,
    input  logic [BUS_W-1:0] pix_bus,
    input  logic             hsync,
    input  logic             vsync,
    output logic             y_valid,
    output logic [SMP_W-1:0] y_data,
    output logic             cb_valid,
    output logic [SMP_W-1:0] cb_data,
    output logic             cr_valid,
    output logic [SMP_W-1:0] cr_data,
    output logic             rgb_active,
    output logic             tc_valid,
    output logic             tc_field,
    output logic             tc_vblank,
    output logic             tc_hblank,
    output logic             tc_blocked,
    output logic             mode_unsup,
    output logic             hsync_out,
    output logic             vsync_out
);
    fmt_e             fmt;
    fmt_e             fmt_q;
    logic             unsup;
    logic             il;
    logic             wide;
    logic             hs_q;
    logic             vs_q;
    logic             hs_rise;
    logic [SMP_W-1:0] word;
    logic [KEY_W-1:0] key;
    logic             code_word;
    logic             xy_hit;
    logic [2:0]       fvh;
    logic [PH_W-1:0]  ph;
    logic             take;
    logic             csel;
    logic             emit;
    logic             sav;
    logic             shift_en;
    smp_t             y_n, cb_n, cr_n;
    smp_t             y_q, cb_q, cr_q;
    logic             tcv_n, blk_n;
    logic [2:0]       fvh_q;
    logic             tcv_q, blk_q, unsup_q;

    vif_mode_dec u_dec (
        .mode_sel (mode_sel),
        .sd_width (sd_width),
        .rgb_sel  (rgb_sel),
        .fmt      (fmt),
        .unsup    (unsup)
    );

    always_comb begin
        il       = fmt_is_il(fmt);
        wide     = fmt_is_wide(fmt);
        hs_rise  = hsync & ~hs_q;
        key      = pix_bus[BUS_W-1:KEY_LSB];
        word     = (fmt == FMT_IL10) ? pix_bus[BUS_W-1:W10_LSB]
                                     : ljust(SMP_W'(key), KEY_W);
        shift_en = il | take;
        emit     = il & ~code_word;
        sav      = il & xy_hit & ~fvh[0];
    end

    vif_code_det u_det (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .key       (key),
        .code_word (code_word),
        .xy_hit    (xy_hit),
        .fvh       (fvh)
    );

    vif_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wide    (wide),
        .hs_rise (hs_rise),
        .emit    (emit),
        .sav     (sav),
        .ph      (ph),
        .take    (take),
        .csel    (csel)
    );

    always_comb begin
        y_n   = '{vld: 1'b0, dat: y_q.dat};
        cb_n  = '{vld: 1'b0, dat: cb_q.dat};
        cr_n  = '{vld: 1'b0, dat: cr_q.dat};
        tcv_n = il & xy_hit;
        blk_n = wide & take & xy_hit;
        if (emit) begin
            case (ph)
                2'd0:    cb_n = '{vld: 1'b1, dat: word};
                2'd2:    cr_n = '{vld: 1'b1, dat: word};
                default: y_n  = '{vld: 1'b1, dat: word};
            endcase
        end else if (take && fmt == FMT_SPLIT) begin
            y_n = '{vld: 1'b1, dat: ljust(SMP_W'(key), KEY_W)};
            if (csel) cr_n = '{vld: 1'b1, dat: ljust(SMP_W'(pix_bus[KEY_W-1:0]), KEY_W)};
            else      cb_n = '{vld: 1'b1, dat: ljust(SMP_W'(pix_bus[KEY_W-1:0]), KEY_W)};
        end else if (take && fmt == FMT_RGB) begin
            y_n  = '{vld: 1'b1, dat: ljust(SMP_W'(pix_bus[G_LSB +: G_W]), G_W)};
            cb_n = '{vld: 1'b1, dat: ljust(SMP_W'(pix_bus[B_LSB +: B_W]), B_W)};
            cr_n = '{vld: 1'b1, dat: ljust(SMP_W'(pix_bus[R_LSB +: R_W]), R_W)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            fmt_q   <= FMT_OFF;
            y_q     <= '0;
            cb_q    <= '0;
            cr_q    <= '0;
            tcv_q   <= 1'b0;
            blk_q   <= 1'b0;
            fvh_q   <= '0;
            unsup_q <= 1'b0;
        end else begin
            hs_q    <= hsync;
            vs_q    <= vsync;
            fmt_q   <= fmt;
            y_q     <= y_n;
            cb_q    <= cb_n;
            cr_q    <= cr_n;
            tcv_q   <= tcv_n;
            blk_q   <= blk_n;
            if (tcv_n) fvh_q <= fvh;
            unsup_q <= unsup;
        end
    end

    assign y_valid    = y_q.vld;
    assign y_data     = y_q.dat;
    assign cb_valid   = cb_q.vld;
    assign cb_data    = cb_q.dat;
    assign cr_valid   = cr_q.vld;
    assign cr_data    = cr_q.dat;
    assign rgb_active = (fmt_q == FMT_RGB);
    assign tc_valid   = tcv_q;
    assign tc_field   = fvh_q[2];
    assign tc_vblank  = fvh_q[1];
    assign tc_hblank  = fvh_q[0];
    assign tc_blocked = blk_q;
    assign mode_unsup = unsup_q;
    assign hsync_out  = hs_q;
    assign vsync_out  = vs_q;

    // R1: an unsupported configuration never drives a strobe
    a_r1_unsup_quiet: assert property (@(posedge clk) disable iff (rst)
        mode_unsup |-> !(y_valid || cb_valid || cr_valid || tc_valid));

    // R5: interleaved words land on one lane only
    a_r5_one_lane: assert property (@(posedge clk) disable iff (rst)
        fmt_is_il(fmt_q) |-> ($countones({y_valid, cb_valid, cr_valid}) <= 1));

    // R6: after a start-of-active code the next emitted word is Cb
    a_r6_sav_restart: assert property (@(posedge clk) disable iff (rst)
        (tc_valid && !tc_hblank) |=> (!(y_valid || cr_valid) || !fmt_is_il(fmt_q)));

    // R7: code words are never emitted as samples
    a_r7_code_not_sample: assert property (@(posedge clk) disable iff (rst)
        tc_valid |-> !(y_valid || cb_valid || cr_valid));

    // R8: split mode samples no faster than every second clock
    a_r8_half_rate: assert property (@(posedge clk) disable iff (rst)
        (y_valid && fmt_q == FMT_SPLIT) |=>
            (!y_valid || $rose(hs_q) || fmt_q != FMT_SPLIT));

    // R10: a blocked code is never also accepted
    a_r10_blocked_excl: assert property (@(posedge clk) disable iff (rst)
        tc_blocked |-> !tc_valid);
endmodule

// File: tb/vid_in_fmt_tb.sv
module vid_in_fmt_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'b000;
    logic [1:0]  sd_width = 2'b00;
    logic        rgb_sel = 1'b0;
    logic [15:0] pix = 16'h0;
    logic        hs = 1'b0;
    logic        vs = 1'b0;
    logic        y_valid, cb_valid, cr_valid, rgb_active;
    logic [9:0]  y_data, cb_data, cr_data;
    logic        tc_valid, tc_field, tc_vblank, tc_hblank, tc_blocked;
    logic        mode_unsup, hsync_out, vsync_out;

    int nvec = 0;
    int nerr = 0;
    int bph  = 0;

    always #2 clk = ~clk;

    vid_in_fmt u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sd_width(sd_width),
        .rgb_sel(rgb_sel), .pix_bus(pix), .hsync(hs), .vsync(vs),
        .y_valid(y_valid), .y_data(y_data), .cb_valid(cb_valid), .cb_data(cb_data),
        .cr_valid(cr_valid), .cr_data(cr_data), .rgb_active(rgb_active),
        .tc_valid(tc_valid), .tc_field(tc_field), .tc_vblank(tc_vblank),
        .tc_hblank(tc_hblank), .tc_blocked(tc_blocked), .mode_unsup(mode_unsup),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] b, input logic h);
        @(negedge clk);
        pix = b;
        hs  = h;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_none(input string tag);
        chk(tag, {29'd0, y_valid, cb_valid, cr_valid}, 32'd0);
    endtask

    // expected lane for interleaved model phase, then advance it
    task automatic chk_il(input string tag, input logic [9:0] w);
        case (bph)
            0: begin chk(tag, {29'd0, y_valid, cb_valid, cr_valid}, 32'b010); chk(tag, cb_data, w); end
            2: begin chk(tag, {29'd0, y_valid, cb_valid, cr_valid}, 32'b001); chk(tag, cr_data, w); end
            default: begin chk(tag, {29'd0, y_valid, cb_valid, cr_valid}, 32'b100); chk(tag, y_data, w); end
        endcase
        bph = (bph + 1) % 4;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(16'h1234, 1'b0);
        cyc(16'h1234, 1'b0);
        chk("R1 reset strobes", {y_valid, cb_valid, cr_valid, tc_valid, tc_blocked, mode_unsup}, 0);
        chk("R1 reset data", {y_data, cb_data, cr_data}, 0);
        @(negedge clk); rst = 1'b0;

        // R1 unsupported mode codes
        for (int m = 1; m < 8; m++) begin
            mode_sel = 3'(m);
            cyc(16'hA5C3, 1'b1);
            cyc(16'h5A3C, 1'b0);
            chk("R1 unsup flag", mode_unsup, 1);
            chk_none("R1 unsup strobes");
        end
        // R2 reserved width and rgb override
        mode_sel = 3'b000; sd_width = 2'b11;
        cyc(16'h0101, 1'b0);
        chk("R2 width 11 unsup", mode_unsup, 1);
        chk_none("R2 width 11 strobes");
        rgb_sel = 1'b1;
        cyc(16'h0101, 1'b0);
        chk("R2 rgb overrides width", mode_unsup, 0);
        rgb_sel = 1'b0;

        // R3 R5 8-bit sweep
        sd_width = 2'b00;
        cyc(16'h0101, 1'b0);
        for (int i = 0; i < 200; i++) begin
            logic [7:0] b;
            b = 8'(1 + (i * 37) % 254);
            if (i == 0) bph = 0;
            cyc({b, 8'(i * 13)}, i == 0);
            chk("R3 R5 8-bit sample", mode_unsup, 0);
            chk_il("R3 R5 8-bit lane", {b, 2'b00});
        end

        // R4 10-bit sweep
        sd_width = 2'b10;
        for (int i = 0; i < 200; i++) begin
            logic [9:0] v;
            v = 10'(4 + (i * 97) % 1016);
            if (i == 0) bph = 0;
            cyc({v, 6'(i)}, i == 0);
            chk_il("R4 10-bit lane", v);
        end

        // R6 R7 embedded codes in 8-bit mode
        sd_width = 2'b00;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 3; j++) begin
                cyc({8'(8'h40 + k * 3 + j), 8'hFF}, 1'b0);
                chk_il("R7 pre-code data", {8'(8'h40 + k * 3 + j), 2'b00});
            end
            cyc(16'hFF00, 1'b0); chk_none("R7 FF word hidden"); chk("R7 no tc", tc_valid, 0);
            cyc(16'h00FF, 1'b0); chk_none("R7 00 word hidden");
            cyc(16'h0012, 1'b0); chk_none("R7 00 word hidden");
            cyc({8'(8'h80 | (k << 4)), 8'h77}, 1'b0);
            chk_none("R7 XY word hidden");
            chk("R7 tc pulse", tc_valid, 1);
            chk("R7 tc bits", {tc_field, tc_vblank, tc_hblank}, 32'(k));
            if ((k & 1) == 0) bph = 0;
            cyc(16'h6600, 1'b0);
            chk("R7 tc one cycle", tc_valid, 0);
            chk_il("R6 after code", {8'h66, 2'b00});
        end

        // R6 hsync restart mid-line in 10-bit mode
        sd_width = 2'b10;
        for (int j = 0; j < 3; j++) begin
            cyc({10'(100 + j), 6'd0}, 1'b0);
            chk_il("R6 pre-hsync", 10'(100 + j));
        end
        bph = 0;
        cyc({10'd300, 6'd0}, 1'b1);
        chk_il("R6 hsync restart Cb", 10'd300);
        cyc({10'd301, 6'd0}, 1'b0);
        chk_il("R6 after hsync Y", 10'd301);

        // R8 16-bit split
        sd_width = 2'b01;
        cyc(16'h0101, 1'b0);
        for (int i = 0; i < 60; i++) begin
            logic [7:0] yb, cb;
            int s;
            s  = i / 2;
            yb = 8'(3 + s * 11);
            cb = 8'(200 - s * 7);
            cyc((i % 2 == 0) ? {yb, cb} : 16'(i * 4099), i == 0);
            if (i % 2 == 0) begin
                chk("R8 luma", y_data, {yb, 2'b00});
                if (s % 2 == 0) begin
                    chk("R8 Cb strobe", {y_valid, cb_valid, cr_valid}, 3'b110);
                    chk("R8 Cb data", cb_data, {cb, 2'b00});
                end else begin
                    chk("R8 Cr strobe", {y_valid, cb_valid, cr_valid}, 3'b101);
                    chk("R8 Cr data", cr_data, {cb, 2'b00});
                end
            end else begin
                chk_none("R8 off cycle");
            end
        end
        // hsync on an off cycle becomes a Cb sample
        cyc(16'h2233, 1'b1);
        chk("R8 hsync realign", {y_valid, cb_valid, cr_valid}, 3'b110);
        cyc(16'h4455, 1'b0);
        chk_none("R8 after realign");

        // R9 RGB sweep
        rgb_sel = 1'b1;
        cyc(16'h0, 1'b0);
        for (int i = 0; i < 256; i++) begin
            logic [15:0] v;
            v = 16'(i * 2531 + 7);
            cyc((i % 2 == 0) ? v : ~v, i == 0);
            if (i % 2 == 0) begin
                chk("R9 strobes", {y_valid, cb_valid, cr_valid, rgb_active}, 4'b1111);
                chk("R9 green", y_data, {v[10:5], 4'b0});
                chk("R9 blue", cb_data, {v[15:11], 5'b0});
                chk("R9 red", cr_data, {v[4:0], 5'b0});
            end else begin
                chk_none("R9 off cycle");
            end
        end

        // R10 code pattern in split mode is data
        rgb_sel = 1'b0;
        cyc(16'h0, 1'b0);
        for (int s = 0; s < 5; s++) begin
            logic [7:0] yb;
            case (s)
                0: yb = 8'h55;
                1: yb = 8'hFF;
                4: yb = 8'h90;
                default: yb = 8'h00;
            endcase
            cyc({yb, 8'h10}, s == 0);
            chk("R10 emitted as sample", {y_valid, y_data}, {1'b1, yb, 2'b00});
            chk("R10 blocked flag", {tc_blocked, tc_valid}, (s == 4) ? 2'b10 : 2'b00);
            cyc({yb, 8'h10}, 1'b0);
            chk("R10 blocked one sample", tc_blocked, 0);
        end

        // R11 sync delay
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); vs = i[1]; hs = i[0];
            @(posedge clk); #1;
            chk("R11 sync delay", {hsync_out, vsync_out}, {i[0], i[1]});
        end

        summary();
        $finish;
    end
endmodule